// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner and Start/Stop Detector

This block sits between the raw clock and data pins of a two-wire serial target and the logic that shifts bytes in and out. Both pins are sampled with the system clock. Each pin then passes through a multi-flop synchronizer and a glitch filter. The filter passes a new level only after it has been seen for a set number of samples in a row. Any pulse narrower than that width, on either line, never reaches the outputs.

From the two clean levels the block derives four single-cycle strobes. A clock rise tells downstream logic to sample input data. A clock fall tells it that it may change output data. A start strobe marks the data line falling while the clock stays high. A stop strobe marks the data line rising while the clock stays high. Start detection runs at all times and depends on nothing downstream, so a repeated start in the middle of a transfer is reported. The filter width is a parameter in system clock cycles. With a 50 MHz clock the default of 3 covers a 50 ns spike budget, and 5 would cover 100 ns.

Top module: `i2c_line_guard`

## Requirements
- R1: While reset is asserted and after it is released, with both raw lines high, `sclLevel` and `sdaLevel` are 1 and all four strobes are 0.
- R2: A pulse on `sclRaw` that lasts fewer than `SPIKE_CYC` clock cycles leaves `sclLevel` unchanged and produces no strobe.
- R3: A pulse on `sdaRaw` that lasts fewer than `SPIKE_CYC` clock cycles leaves `sdaLevel` unchanged and produces no strobe. This holds even when the pulse would form a start or stop while SCL is high.
- R4: A raw level change that is held steady appears on the matching filtered output at the (`SPIKE_CYC`+2)-th rising clock edge after the change. Two of those edges are synchronizer stages.
- R5: `sclRise` is 1 for exactly one cycle: the first cycle in which `sclLevel` is 1 after having been 0.
- R6: `sclFall` is 1 for exactly one cycle: the first cycle in which `sclLevel` is 0 after having been 1.
- R7: `startDet` is 1 for exactly one cycle: the first cycle in which `sdaLevel` is 0 after being 1, provided `sclLevel` is 1 in that cycle and in the one before. A repeated start with no stop before it is detected the same way.
- R8: `stopDet` is 1 for exactly one cycle: the first cycle in which `sdaLevel` is 1 after being 0, provided `sclLevel` is 1 in that cycle and in the one before.
- R9: A data-line change while `sclLevel` is 0 gives neither `startDet` nor `stopDet`.
- R10: A data-line change whose filtered edge lands in the same cycle as a filtered clock edge gives only the clock strobe. No start or stop is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclRaw | input | 1 | Unsynchronized serial clock pin level |
| sdaRaw | input | 1 | Unsynchronized serial data pin level |
| sclLevel | output | 1 | Filtered clock line level |
| sdaLevel | output | 1 | Filtered data line level |
| sclRise | output | 1 | One-cycle strobe: filtered clock rose |
| sclFall | output | 1 | One-cycle strobe: filtered clock fell |
| startDet | output | 1 | One-cycle strobe: start condition |
| stopDet | output | 1 | One-cycle strobe: stop condition |

## Verification
A filtered clock edge and a filtered data edge can fall in the same cycle. When that happens the data edge could be read as a start or a stop. The bench provokes this by changing both raw lines on the same sampling edge, so both filters flip at the same edge. It does this for all four combinations of direction. The scoreboard then expects only the clock strobe at the predicted cycle and reports any start or stop strobe in that cycle as an error.

// File: rtl/i2c_line_guard_pkg.sv
package i2c_line_guard_pkg;

  // Filtered levels handed from datapath to control, with last-cycle copies.
  typedef struct packed {
    logic scl;
    logic sda;
    logic sclPrev;
    logic sdaPrev;
  } line_view_t;

  // Strobes produced by control.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } bus_strobe_t;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
  localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPIKE_CYC   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int unsigned CW = (SPIKE_CYC > 1) ? $clog2(SPIKE_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(SPIKE_CYC - 1);

  logic [SYNC_STAGES-1:0] syncSh;
  logic                   syncIn;
  logic [CW-1:0]          runCnt;

  assign syncIn = syncSh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncSh <= '1;
    else       syncSh <= {syncSh[SYNC_STAGES-2:0], rawIn};
  end

  // Count consecutive samples that differ from the held level.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= 1'b1;
      runCnt <= '0;
    end else if (syncIn == level) begin
      runCnt <= '0;
    end else if (runCnt == LIMIT) begin
      level  <= syncIn;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R4 the filtered level only moves toward a value the synchronizer showed
  level_follows_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ($past(syncIn) == level));

  // R2 R3 a flip needs at least two cycles of the differing value at the sync output
  no_single_sample_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((level != $past(level)) && (SPIKE_CYC > 1)) |-> ($past(syncIn, 2) == level));

endmodule

// File: rtl/i2c_line_path.sv
module i2c_line_path
  import i2c_line_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPIKE_CYC   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRaw,
  input  logic       sdaRaw,
  output line_view_t view
);
  logic [NUM_LINES-1:0] rawVec;
  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] lvlPrev;

  assign rawVec[LINE_SCL] = sclRaw;
  assign rawVec[LINE_SDA] = sdaRaw;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .SPIKE_CYC  (SPIKE_CYC)
    ) u_filt (
      .clk  (clk),
      .rstN (rstN),
      .rawIn(rawVec[g]),
      .level(lvl[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) lvlPrev <= '1;
    else       lvlPrev <= lvl;
  end

  assign view.scl     = lvl[LINE_SCL];
  assign view.sda     = lvl[LINE_SDA];
  assign view.sclPrev = lvlPrev[LINE_SCL];
  assign view.sdaPrev = lvlPrev[LINE_SDA];

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_line_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  line_view_t  view,
  output bus_strobe_t strb
);
  logic sclHeld;

  assign sclHeld      = view.scl & view.sclPrev;
  assign strb.sclRise = view.scl & ~view.sclPrev;
  assign strb.sclFall = ~view.scl & view.sclPrev;
  assign strb.start   = sclHeld & ~view.sda & view.sdaPrev;
  assign strb.stop    = sclHeld & view.sda & ~view.sdaPrev;

  // R5 R6 clock strobes are exclusive and last one cycle
  scl_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sclRise, strb.sclFall}));

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sclRise |=> !strb.sclRise);

  // R7 R8
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.start && strb.stop));

  // R7 start implies clock was high last cycle and data was high
  start_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> ($past(view.scl) && $past(view.sda) && view.scl && !view.sda));

  // R8
  stop_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stop |-> ($past(view.scl) && !$past(view.sda) && view.scl && view.sda));

  // R10 a condition never shares a cycle with a clock edge
  cond_no_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start || strb.stop) |-> !(strb.sclRise || strb.sclFall));

endmodule

// File: rtl/i2c_line_guard.sv
module i2c_line_guard
  import i2c_line_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPIKE_CYC   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  line_view_t  view;
  bus_strobe_t strb;

  i2c_line_path #(
    .SYNC_STAGES(SYNC_STAGES),
    .SPIKE_CYC  (SPIKE_CYC)
  ) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .sclRaw(sclRaw),
    .sdaRaw(sdaRaw),
    .view  (view)
  );

  i2c_cond_ctrl u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .view(view),
    .strb(strb)
  );

  assign sclLevel = view.scl;
  assign sdaLevel = view.sda;
  assign sclRise  = strb.sclRise;
  assign sclFall  = strb.sclFall;
  assign startDet = strb.start;
  assign stopDet  = strb.stop;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (sclLevel && sdaLevel && !startDet && !stopDet));

endmodule

// File: tb/i2c_line_guard_test.sv
module i2c_line_guard_test;
  localparam int SPK = 3;
  localparam int LAT = SPK + 2;

  typedef struct {
    int    kind;   // 0 rise, 1 fall, 2 start, 3 stop
    int    cyc;
    string req;
  } evt_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRaw = 1'b1;
  logic sdaRaw = 1'b1;
  logic sclLevel, sdaLevel, sclRise, sclFall, startDet, stopDet;

  int    cyc = 0;
  int    errors = 0;
  int    checks = 0;
  bit    mScl = 1'b1;
  bit    mSda = 1'b1;
  string curReq = "R1";
  evt_t  q[$];
  bit    done = 1'b0;

  always #10 clk = ~clk;

  i2c_line_guard #(.SYNC_STAGES(2), .SPIKE_CYC(SPK)) uut (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectOne(input int kind);
    evt_t e;
    checks++;
    if (q.size() == 0 || q[0].kind != kind) begin
      errors++;
      $display("FAIL %s: unexpected strobe kind=%0d at cycle %0d (expected %s)",
               curReq, kind, cyc, (q.size() == 0) ? "none" : $sformatf("kind=%0d", q[0].kind));
    end else begin
      e = q.pop_front();
      if (e.cyc != cyc) begin
        errors++;
        $display("FAIL %s: strobe kind=%0d at cycle %0d, expected cycle %0d", e.req, kind, cyc, e.cyc);
      end
    end
  endtask

  // Monitor: compare produced strobes with the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sclRise)  expectOne(0);
      if (sclFall)  expectOne(1);
      if (startDet) expectOne(2);
      if (stopDet)  expectOne(3);
      if (q.size() != 0 && q[0].cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: missing strobe kind=%0d, actual none, expected at cycle %0d",
                 q[0].req, q[0].kind, q[0].cyc);
        void'(q.pop_front());
      end
    end
  end

  task automatic push(input int kind, input int at, input string req);
    evt_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic checkLevels(input string req);
    checks++;
    if (sclLevel !== mScl || sdaLevel !== mSda) begin
      errors++;
      $display("FAIL %s: levels scl=%b sda=%b, expected scl=%b sda=%b",
               req, sclLevel, sdaLevel, mScl, mSda);
    end
  endtask

  // Driver: move both raw lines, predict strobes from the requirements.
  task automatic move(input bit s, input bit d, input string req);
    int at;
    @(negedge clk);
    curReq = req;
    at = cyc + LAT;
    if (s && !mScl) push(0, at, "R5");
    if (!s && mScl) push(1, at, "R6");
    if (s && mScl && !d && mSda) push(2, at, "R7");
    if (s && mScl && d && !mSda) push(3, at, "R8");
    sclRaw = s;
    sdaRaw = d;
    mScl = s;
    mSda = d;
    repeat (LAT - 1) @(negedge clk);
    checks++;
    if ((sclLevel === s && s !== mScl) || (sdaLevel === d && d !== mSda)) begin
      errors++;
      $display("FAIL R4: level moved early");
    end
    @(negedge clk);
    checkLevels("R4");
    repeat (3) @(negedge clk);
  endtask

  task automatic glitch(input bit onScl, input string req);
    @(negedge clk);
    curReq = req;
    if (onScl) sclRaw = ~mScl; else sdaRaw = ~mSda;
    repeat (SPK - 1) @(negedge clk);
    sclRaw = mScl;
    sdaRaw = mSda;
    repeat (LAT + 3) @(negedge clk);
    checkLevels(req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checkLevels("R1");
    checks++;
    if (sclRise || sclFall || startDet || stopDet) begin
      errors++;
      $display("FAIL R1: strobes active in reset, actual=%b%b%b%b expected=0000",
               sclRise, sclFall, startDet, stopDet);
    end
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkLevels("R1");

    glitch(1'b0, "R3");        // SDA low spike with SCL high: no start
    glitch(1'b1, "R2");
    move(1, 0, "R7");          // start
    move(0, 0, "R6");
    move(0, 1, "R9");          // data rises with clock low
    glitch(1'b1, "R2");        // clock spike while low
    move(1, 1, "R5");
    move(1, 0, "R7");          // repeated start
    move(0, 0, "R6");
    move(0, 1, "R9");
    move(0, 0, "R9");
    move(1, 0, "R5");
    glitch(1'b0, "R3");        // SDA high spike with SCL high: no stop
    move(1, 1, "R8");          // stop
    move(0, 0, "R10");         // clock falls, data falls same edge
    move(1, 1, "R10");         // clock rises, data rises same edge
    move(1, 0, "R7");
    move(0, 1, "R10");         // clock falls, data rises
    move(1, 0, "R10");         // clock rises, data falls
    move(1, 1, "R8");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d strobes never seen, expected 0", q[0].req, q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule